// File: doc/BRIEF.md
# Configurable I2S Frame Serializer

This block turns a stream of stereo sample pairs into a serial audio line. It generates its own bit clock from the system clock through a half-period divider, drives a left/right word clock, and shifts each sample out most significant bit first. One set of static configuration inputs selects the framing: whether the first data bit is delayed by one bit clock after the word-clock edge (I2S style) or aligned to it (left-justified), whether the sample sits at the start or the end of its channel slot, the sample word length, the slot width, and the polarity of both clocks.

Samples come from an upstream FIFO through a valid flag and two data words. The block takes one pair per frame, at the moment the first bit of the left slot is launched, and acknowledges it with a one-cycle request strobe. If no pair is waiting at that moment the frame carries zeros and a one-cycle underflow strobe is raised instead. Configuration is expected to change only while reset is held.

Top module: `i2s_frame_ser`

## Requirements
- R1: The internal bit clock has a period of 2*HALF_DIV system cycles with equal halves; sclk_o equals this clock when cfg_bpol_i is 0 and its inverse when 1. Data bits on sd_o change only at the launch edge (falling edge of sclk_o when cfg_bpol_i is 0, rising edge when 1) and are stable at the opposite capture edge.
- R2: A frame is two channel slots, left then right. The slot width code cfg_slot_i selects 16 (code 0), 32 (code 1) or 64 (codes 2 and 3) bit clocks per slot.
- R3: ws_o equals cfg_lrpol_i for every bit of the left slot and its inverse for every bit of the right slot; with cfg_lrpol_i at 0 the word clock is low during the left word.
- R4: With cfg_delay_i at 1 the first data bit of a slot is sent one bit clock after the word-clock transition that opens the slot (the last bit of the right slot then falls in the next frame's first bit period); with cfg_delay_i at 0 it is sent in the same bit period as that transition.
- R5: The word-length code cfg_wlen_i selects 16 (code 0), 24 (code 1) or 32 (codes 2 and 3) bits; the sample occupies the low bits of its input word and is sent MSB first.
- R6: With cfg_rjust_i at 0 the sample fills the first bits of the slot; with cfg_rjust_i at 1 its LSB is the last bit of the slot. All slot bits not carrying sample data are driven to 0.
- R7: When the word length exceeds the slot width, only the most significant slot-width bits of the sample are sent.
- R8: A new pair is taken at the launch of the first data bit of the left slot; if smp_valid_i is 1 there, smp_req_o is high for exactly the next system cycle and the frame carries smp_left_i in the left slot and smp_right_i in the right slot.
- R9: If smp_valid_i is 0 at that launch, underflow_o is high for exactly the next system cycle, smp_req_o stays low and both slots of that frame carry zeros.
- R10: After reset the serializer starts at the first bit of the left slot with cleared data; the first pair is taken at the first data-frame start, which is the second bit launch when cfg_delay_i is 1 and the start of the second frame when cfg_delay_i is 0.
- R11: While rst_n is low, regardless of the clock, sd_o is 0, smp_req_o and underflow_o are 0, sclk_o equals cfg_bpol_i and ws_o equals cfg_lrpol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_delay_i | input | 1 | 1: first data bit one bit clock after the word-clock edge |
| cfg_rjust_i | input | 1 | 1: sample LSB placed at the end of the slot |
| cfg_lrpol_i | input | 1 | Word-clock level during the left slot |
| cfg_bpol_i | input | 1 | Bit-clock polarity: 0 launches on falling edges, 1 on rising edges |
| cfg_wlen_i | input | 2 | Word-length code (16/24/32 bits) |
| cfg_slot_i | input | 2 | Slot-width code (16/32/64 bit clocks) |
| smp_valid_i | input | 1 | A sample pair is waiting upstream |
| smp_left_i | input | SAMPLE_W | Left sample, right-aligned in the word |
| smp_right_i | input | SAMPLE_W | Right sample, right-aligned in the word |
| sclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Left/right word clock |
| sd_o | output | 1 | Serial data |
| smp_req_o | output | 1 | One-cycle strobe: pair taken |
| underflow_o | output | 1 | One-cycle strobe: no pair was available |

## Verification
The embedded properties watch, on every cycle, that the bit clock changes phase only on a divider tick, that data and word clock move only at launch ticks, that the frame position never leaves the selected frame, and that the request and underflow strobes are single-cycle, mutually exclusive and caused by the valid level at the latch point. The actual bit content of a frame (delay, justification, truncation, zero padding, word-clock polarity and the order of pairs across frames, including the silent first frame and underflowed frames) can only be shown by the bench decoding the serial line at capture edges against its own model for a range of configurations, together with the asynchronous reset values.

// File: rtl/i2s_ser_pkg.sv
`timescale 1ns/1ps
package i2s_ser_pkg;

  // Frame positions reach 2*64-1, slot offsets reach 63.
  localparam int unsigned POS_W  = 7;
  localparam int unsigned SLOT_W = 6;

  // Bit clocks per channel slot for a slot-width code.
  function automatic logic [POS_W-1:0] slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    return POS_W'(16);
      2'd1:    return POS_W'(32);
      default: return POS_W'(64);
    endcase
  endfunction

  // Sample bits for a word-length code.
  function automatic logic [POS_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return POS_W'(16);
      2'd1:    return POS_W'(24);
      default: return POS_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/i2s_bit_timer.sv
`timescale 1ns/1ps
module i2s_bit_timer #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic launch_o,
  output logic phase_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             tick;

  always_comb begin
    tick    = (cnt_q == CNT_LAST);
    cnt_d   = tick ? '0 : cnt_q + CNT_W'(1);
    phase_d = tick ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  // Launch happens as the internal clock falls (high half ends).
  assign launch_o = tick & phase_q;
  assign phase_o  = phase_q;

  // R1
  phase_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> $past(tick));

endmodule

// File: rtl/i2s_frame_ctr.sv
`timescale 1ns/1ps
module i2s_frame_ctr
  import i2s_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              delay_i,
  input  logic [POS_W-1:0]  slen_i,
  output logic              ws_nxt_o,
  output logic              dchan_nxt_o,
  output logic [SLOT_W-1:0] dk_nxt_o,
  output logic              fstart_nxt_o
);
  logic [POS_W:0]    flen;
  logic [POS_W-1:0]  flen_m1;
  logic [SLOT_W-1:0] slen_m1;
  logic [POS_W-1:0]  pos_q, pos_d, pos_nxt, dq;

  always_comb begin
    flen    = {slen_i, 1'b0};
    flen_m1 = POS_W'(flen - (POS_W+1)'(1));
    slen_m1 = SLOT_W'(slen_i - POS_W'(1));
    pos_nxt = (pos_q == flen_m1) ? '0 : pos_q + POS_W'(1);
    pos_d   = launch_i ? pos_nxt : pos_q;
    // Data position lags the word-clock position by the first-bit delay.
    if (delay_i)
      dq = (pos_nxt == '0) ? flen_m1 : pos_nxt - POS_W'(1);
    else
      dq = pos_nxt;
    ws_nxt_o     = (pos_nxt >= slen_i);
    dchan_nxt_o  = (dq >= slen_i);
    dk_nxt_o     = dq[SLOT_W-1:0] & slen_m1;
    fstart_nxt_o = (dq == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pos_q} < flen);

endmodule

// File: rtl/i2s_slot_mux.sv
`timescale 1ns/1ps
module i2s_slot_mux
  import i2s_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SLOT_W-1:0]   k_i,
  input  logic [POS_W-1:0]    slen_i,
  input  logic [POS_W-1:0]    wlen_i,
  input  logic                rjust_i,
  output logic                bit_o
);
  localparam int unsigned IDX_W = $clog2(SAMPLE_W);

  logic [POS_W-1:0] nbits, off, kx, rel;
  logic [IDX_W-1:0] idx;
  logic             inwin;

  always_comb begin
    nbits = (wlen_i < slen_i) ? wlen_i : slen_i;
    off   = rjust_i ? slen_i - nbits : '0;
    kx    = {1'b0, k_i};
    rel   = kx - off;
    inwin = (kx >= off) && (rel < nbits);
    idx   = IDX_W'(wlen_i - POS_W'(1) - rel);
    bit_o = inwin ? sample_i[idx] : 1'b0;
  end

endmodule

// File: rtl/i2s_frame_ser.sv
`timescale 1ns/1ps
module i2s_frame_ser
  import i2s_ser_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_delay_i,
  input  logic                cfg_rjust_i,
  input  logic                cfg_lrpol_i,
  input  logic                cfg_bpol_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic [1:0]          cfg_slot_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_left_i,
  input  logic [SAMPLE_W-1:0] smp_right_i,
  output logic                sclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                smp_req_o,
  output logic                underflow_o
);
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic              launch, phase;
  logic [POS_W-1:0]  slen, wlen;
  logic              ws_nxt, dchan_nxt, fstart_nxt;
  logic [SLOT_W-1:0] dk_nxt;

  assign slen = slot_bits(cfg_slot_i);
  assign wlen = word_bits(cfg_wlen_i);

  i2s_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .launch_o (launch),
    .phase_o  (phase)
  );

  i2s_frame_ctr u_ctr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .launch_i     (launch),
    .delay_i      (cfg_delay_i),
    .slen_i       (slen),
    .ws_nxt_o     (ws_nxt),
    .dchan_nxt_o  (dchan_nxt),
    .dk_nxt_o     (dk_nxt),
    .fstart_nxt_o (fstart_nxt)
  );

  logic [SAMPLE_W-1:0] cur_l_q, cur_l_d, cur_r_q, cur_r_d;
  logic [SAMPLE_W-1:0] src_l, src_r, pick;
  logic                latch_now, nxt_bit;
  logic                sd_q, sd_d, ws_q, ws_d;
  logic                req_q, req_d, uf_q, uf_d;

  always_comb begin
    latch_now = launch & fstart_nxt;
    if (latch_now) begin
      src_l = smp_valid_i ? smp_left_i  : '0;
      src_r = smp_valid_i ? smp_right_i : '0;
    end else begin
      src_l = cur_l_q;
      src_r = cur_r_q;
    end
    pick = dchan_nxt ? src_r : src_l;
  end

  i2s_slot_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .sample_i (pick),
    .k_i      (dk_nxt),
    .slen_i   (slen),
    .wlen_i   (wlen),
    .rjust_i  (cfg_rjust_i),
    .bit_o    (nxt_bit)
  );

  always_comb begin
    cur_l_d = src_l;
    cur_r_d = src_r;
    sd_d    = launch ? nxt_bit : sd_q;
    ws_d    = launch ? ws_nxt  : ws_q;
    req_d   = latch_now &  smp_valid_i;
    uf_d    = latch_now & ~smp_valid_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_l_q <= '0;
      cur_r_q <= '0;
      sd_q    <= 1'b0;
      ws_q    <= 1'b0;
      req_q   <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      cur_l_q <= cur_l_d;
      cur_r_q <= cur_r_d;
      sd_q    <= sd_d;
      ws_q    <= ws_d;
      req_q   <= req_d;
      uf_q    <= uf_d;
    end
  end

  assign sclk_o      = phase ^ cfg_bpol_i;
  assign ws_o        = ws_q  ^ cfg_lrpol_i;
  assign sd_o        = sd_q;
  assign smp_req_o   = req_q;
  assign underflow_o = uf_q;

  // R1
  sd_launch_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sd_q) |-> $past(launch));

  // R3
  ws_launch_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(ws_q) |-> $past(launch));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({req_q, uf_q}));

  // R8
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_q |-> $past(smp_valid_i));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_q |=> !req_q);

  // R9
  uf_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    uf_q |-> !$past(smp_valid_i));

endmodule

// File: tb/tb_i2s_frame_ser.sv
`timescale 1ns/1ps
module tb_i2s_frame_ser;
  localparam int HALF = 2;
  localparam int NVEC = 9;
  // Fields: {delay, rjust, lrpol, bpol, wlen[1:0], slot[1:0], pairs[1:0]}
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1, 2'd3},
    {1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd2, 2'd2},
    {1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 2'd3},
    {1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 2'd2},
    {1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2, 2'd1},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},
    {1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 2'd3, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_delay, cfg_rjust, cfg_lrpol, cfg_bpol;
  logic [1:0] cfg_wlen, cfg_slot;
  logic smp_valid;
  logic [31:0] smp_left, smp_right;
  logic sclk_o, ws_o, sd_o, smp_req_o, underflow_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  i2s_frame_ser #(.HALF_DIV(HALF), .SAMPLE_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_delay_i(cfg_delay), .cfg_rjust_i(cfg_rjust),
    .cfg_lrpol_i(cfg_lrpol), .cfg_bpol_i(cfg_bpol),
    .cfg_wlen_i(cfg_wlen), .cfg_slot_i(cfg_slot),
    .smp_valid_i(smp_valid), .smp_left_i(smp_left), .smp_right_i(smp_right),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .smp_req_o(smp_req_o), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int v, int i, int ch);
    return (32'h8D3B_6E41 * 32'(v*8 + i*2 + ch + 1)) ^ 32'h0F1E_2D3C;
  endfunction

  function automatic int wl_len(logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  function automatic int sl_len(logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 32 : 64;
  endfunction

  // Expected data bit at capture n after reset, from R4..R10.
  function automatic logic exp_bit(int v, int n, logic d, logic rj, int wl, int sl, int np);
    int q, f, r, k, pi, nb, off, ch;
    logic [31:0] s;
    q = n - (d ? 1 : 0);
    if (q < 0) return 1'b0;
    f  = q / (2*sl);
    r  = q % (2*sl);
    ch = (r >= sl) ? 1 : 0;
    k  = r % sl;
    pi = d ? f : f - 1;
    if (pi < 0 || pi >= np) return 1'b0;
    s   = pat(v, pi, ch);
    nb  = (wl < sl) ? wl : sl;
    off = rj ? sl - nb : 0;
    if (k < off || k >= off + nb) return 1'b0;
    return s[wl - 1 - (k - off)];
  endfunction

  task automatic drive_pair(int v, int idx, int np);
    smp_valid = (idx < np);
    smp_left  = (idx < np) ? pat(v, idx, 0) : 32'h0;
    smp_right = (idx < np) ? pat(v, idx, 1) : 32'h0;
  endtask

  task automatic run_vec(int v);
    logic [9:0] vc;
    int wl, sl, np, idx, cap, cyc, last, mism, wsm, perr, reqc, ufc, lat;
    logic s, prev_s, e, ew;
    vc = VEC[v];
    cfg_delay = vc[9]; cfg_rjust = vc[8]; cfg_lrpol = vc[7]; cfg_bpol = vc[6];
    cfg_wlen = vc[5:4]; cfg_slot = vc[3:2]; np = int'(vc[1:0]);
    wl = wl_len(cfg_wlen); sl = sl_len(cfg_slot);
    idx = 0;
    drive_pair(v, idx, np);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R11 R1: reset levels of every output
    chk({sclk_o, ws_o, sd_o, smp_req_o, underflow_o} === {cfg_bpol, cfg_lrpol, 3'b000},
        "R11", $sformatf("vec%0d reset outputs", v),
        {59'd0, sclk_o, ws_o, sd_o, smp_req_o, underflow_o},
        {59'd0, cfg_bpol, cfg_lrpol, 3'b000});
    rst_n = 1'b1;
    cap = 0; cyc = 0; last = 0; mism = 0; wsm = 0; perr = 0; reqc = 0; ufc = 0;
    prev_s = 1'b0;
    while (cap < 8*sl && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (smp_req_o === 1'b1) begin
        reqc++;
        idx++;
        drive_pair(v, idx, np);
      end
      if (underflow_o === 1'b1) ufc++;
      s = sclk_o ^ cfg_bpol;
      if (!prev_s && s) begin
        if (cap > 0 && (cyc - last) != 2*HALF) perr++;
        last = cyc;
        e  = exp_bit(v, cap, cfg_delay, cfg_rjust, wl, sl, np);
        ew = ((cap % (2*sl)) >= sl) ? ~cfg_lrpol : cfg_lrpol;
        if (sd_o !== e) mism++;
        if (ws_o !== ew) wsm++;
        cap++;
      end
      prev_s = s;
    end
    lat = cfg_delay ? 4 : 3;
    chk(cap == 8*sl, "R1", $sformatf("vec%0d capture edges seen", v), 64'(cap), 64'(8*sl));
    chk(perr == 0, "R1", $sformatf("vec%0d bit period errors", v), 64'(perr), 64'd0);
    // R4 R5 R6 R7 R10: serial content bit by bit
    chk(mism == 0, "R4 R5 R6 R7 R10", $sformatf("vec%0d data bit mismatches", v),
        64'(mism), 64'd0);
    // R2 R3: word clock level per slot
    chk(wsm == 0, "R2 R3", $sformatf("vec%0d word clock mismatches", v), 64'(wsm), 64'd0);
    chk(reqc == ((np < lat) ? np : lat), "R8", $sformatf("vec%0d request strobes", v),
        64'(reqc), 64'((np < lat) ? np : lat));
    chk(ufc == ((np < lat) ? lat - np : 0), "R9", $sformatf("vec%0d underflow strobes", v),
        64'(ufc), 64'((np < lat) ? lat - np : 0));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_delay = 1'b0; cfg_rjust = 1'b0; cfg_lrpol = 1'b0; cfg_bpol = 1'b0;
    cfg_wlen = 2'd0; cfg_slot = 2'd0;
    smp_valid = 1'b0; smp_left = '0; smp_right = '0;
    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R11: reset asserted mid-frame between clock edges takes effect at once
    cfg_delay = 1'b1; cfg_rjust = 1'b0; cfg_lrpol = 1'b1; cfg_bpol = 1'b1;
    cfg_wlen = 2'd0; cfg_slot = 2'd0;
    smp_valid = 1'b1; smp_left = 32'h0000_FFFF; smp_right = 32'h0000_FFFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (37) @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk({sclk_o, ws_o, sd_o, smp_req_o, underflow_o} === 5'b11000, "R11",
        "async reset outputs", {59'd0, sclk_o, ws_o, sd_o, smp_req_o, underflow_o},
        64'b11000);
    // R9: with valid low from reset only underflow strobes appear
    smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int rq, uf;
      rq = 0; uf = 0;
      repeat (400) begin
        @(negedge clk);
        if (smp_req_o === 1'b1) rq++;
        if (underflow_o === 1'b1) uf++;
      end
      chk(rq == 0, "R9", "requests while starved", 64'(rq), 64'd0);
      chk(uf > 0 && sd_o === 1'b0, "R9", "underflow seen and line quiet",
          64'(uf), 64'd1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule